// File: doc/BRIEF.md
# Deep Standby Wake and Pin-Hold Controller

This block puts a small controller-style system into a deep low-power standby state and brings it back out. A sleep request arms standby. From then on only the wake events chosen in a select mask can end it. The available events are a non-maskable interrupt, a configurable number of IRQ lines and a manual reset. Every chosen event that fires latches its own flag, so software can see after wake-up what ended standby.

Pad levels are frozen through two hold outputs. One covers the external-bus control pins and the other covers every remaining pin. Both are raised at entry. When the system boots from the external bus, the bus-control hold drops by itself at wake so that code can be fetched. When it boots from on-chip RAM, both holds stay up. Software frees the pins once it has rebuilt the peripheral setup. It does this by reading the hold bit as 1 and then writing 0 to it.

A small register port gives access to the wake mask, the flags with the hold bit, and a status word.

Top module: `dsw_ctrl`

## Requirements
- R1: After reset, standby, the wake pulse and both holds are 0, and registers 0 and 1 read 0.
- R2: A sleep request with no selected event in the same cycle raises standby in the next cycle. Both holds and the hold bit (bit NSRC of register 1) are also raised in that cycle.
- R3: While in standby, any event whose mask bit is 0 is ignored. Standby stays 1 and no flag changes.
- R4: A selected event sampled in standby has three effects in the next cycle: standby drops, the wake pulse is 1 for exactly one cycle, and the event's flag is set.
- R5: When several selected events arrive together, every one of their flags is set.
- R6: With external-bus boot (boot_ram = 0), the bus-control hold drops at wake while the other-pin hold stays 1.
- R7: With on-chip RAM boot (boot_ram = 1), both holds stay 1 after wake.
- R8: A read of register 1 that returns the hold bit as 1, followed by a write of register 1 with the hold bit 0, clears the hold bit and both holds.
- R9: A write of 0 to the hold bit with no prior read of 1 has no effect. A write of 1 to the hold bit cancels a pending read.
- R10: A sleep request in the same cycle as a selected event causes no entry. Standby stays 0, the wake pulse fires and the flag is set.
- R11: A flag clears when 1 is written to its bit of register 1. Software cannot set the hold bit.
- R12: Event bit order is the same in the mask (register 0) and the flags (register 1): bit 0 is NMI, bit 1 is manual reset, and bit 2+i is IRQ i. Register 2 shows standby in bit 0 and boot_ram in bit 1. Register select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Request to enter deep standby |
| nmi | input | 1 | Non-maskable interrupt event |
| mres | input | 1 | Manual reset event |
| irq | input | NUM_IRQ | IRQ events |
| boot_ram | input | 1 | 1 = on-chip RAM boot, 0 = external-bus boot |
| reg_sel | input | 2 | Register select |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | NUM_IRQ+3 | Write data |
| reg_rdata | output | NUM_IRQ+3 | Read data of the selected register |
| standby_o | output | 1 | Deep standby active |
| wake_pulse_o | output | 1 | One-cycle pulse at wake or cancelled entry |
| hold_bus_o | output | 1 | Hold for the external-bus control pins |
| hold_io_o | output | 1 | Hold for all other pins |

## Verification
On every cycle, the assertions check the following:
- Standby survives unselected events.
- A selected event drops standby with a pulse.
- A cancelled entry never raises standby.
- Flags only fall when cleared, and every captured event sets its flag.
- The bus hold follows the boot mode at wake.
- The other-pin hold only falls after a read-armed write.

The bench's scenarios are needed for the rest: that register contents line up with the event bit order, that software cannot set the hold bit, and that an unarmed write or a write of 1 leaves the pins held.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
    // Register offsets of the controller's register port
    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_FLAG = 2'd1,
        REG_STAT = 2'd2
    } dsw_reg_e;

    // Bit positions of the wake events in mask and flag registers
    localparam int SRC_NMI  = 0;
    localparam int SRC_MRES = 1;
    localparam int SRC_IRQ0 = 2;
endpackage

// File: rtl/dsw_seq.sv
// Standby sequencer.
// Tracks whether deep standby is active and produces the entry and wake strobes.
// Assumes ev_qual already holds only the events selected by the wake mask.
module dsw_seq #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic [NSRC-1:0] ev_qual,
    output logic            standby_o,
    output logic            wake_pulse_o,
    output logic            enter_o,
    output logic            wake_o,
    output logic            capture_o
);
    logic standby_q;
    logic pulse_q;
    logic hit;

    // Decode entry, wake and capture conditions from the current state
    always_comb begin
        hit       = |ev_qual;
        capture_o = standby_q | sleep_req;
        enter_o   = !standby_q && sleep_req && !hit;
        wake_o    = capture_o && hit;
    end

    // Standby state and one-cycle wake pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            standby_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= wake_o;
            if (enter_o)
                standby_q <= 1'b1;
            else if (wake_o)
                standby_q <= 1'b0;
        end
    end

    assign standby_o    = standby_q;
    assign wake_pulse_o = pulse_q;

    assert_masked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_q && ev_qual == '0) |=> standby_q);
    assert_wake_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_q && ev_qual != '0) |=> (!standby_q && pulse_q));
    assert_cancel_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_q && sleep_req && ev_qual != '0) |=> (!standby_q && pulse_q));
endmodule

// File: rtl/dsw_flags.sv
// Wake-source flag bank.
// Latches every selected event seen while standby is active or being requested.
// Software clears a flag by writing 1 to it; a set in the same cycle wins.
module dsw_flags #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [NSRC-1:0] ev_qual,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] flags_o
);
    logic [NSRC-1:0] flags_q;

    // One flag per event source, set over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            for (int i = 0; i < NSRC; i++)
                if (capture && ev_qual[i])
                    flags_q[i] <= 1'b1;
                else if (clr_mask[i])
                    flags_q[i] <= 1'b0;
    end

    assign flags_o = flags_q;

    assert_all_flags_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ((flags_q & $past(ev_qual)) == $past(ev_qual)));
    assert_flag_fall_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags_q) & ~flags_q) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/dsw_retain.sv
// Pin-hold keeper.
// Raises both pad holds and the hold bit at standby entry. Drops the bus hold at
// wake for external-bus boot. Releases everything after a read-1 / write-0
// handshake on the hold bit, and only outside standby.
module dsw_retain (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic enter,
    input  logic wake,
    input  logic boot_ram,
    input  logic rd_keep,
    input  logic wr_keep,
    input  logic wdata_keep,
    output logic keep_o,
    output logic hold_bus_o,
    output logic hold_io_o
);
    logic keep_q;
    logic armed_q;
    logic bus_q;
    logic io_q;
    logic release_w;

    // Release only when armed by a read of 1 and written with 0
    always_comb release_w = wr_keep && armed_q && !wdata_keep && !standby;

    // Read-then-write handshake tracker
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (enter || wr_keep)
            armed_q <= 1'b0;
        else if (rd_keep && keep_q)
            armed_q <= 1'b1;
    end

    // Hold bit and the two pad-hold groups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= 1'b0;
            bus_q  <= 1'b0;
            io_q   <= 1'b0;
        end else if (enter) begin
            keep_q <= 1'b1;
            bus_q  <= 1'b1;
            io_q   <= 1'b1;
        end else if (release_w) begin
            keep_q <= 1'b0;
            bus_q  <= 1'b0;
            io_q   <= 1'b0;
        end else if (wake && standby && !boot_ram) begin
            bus_q  <= 1'b0;
        end
    end

    assign keep_o     = keep_q;
    assign hold_bus_o = bus_q;
    assign hold_io_o  = io_q;

    assert_ext_boot_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && standby && !boot_ram) |=> (!bus_q && io_q));
    assert_ram_boot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && standby && boot_ram) |=> (bus_q && io_q));
    assert_io_release_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_q) |-> ($past(armed_q) && $past(wr_keep) && !$past(wdata_keep)));
endmodule

// File: rtl/dsw_ctrl.sv
// Deep standby wake and pin-hold controller (top).
// Holds the wake mask, qualifies the raw events, decodes the register port and
// ties together the sequencer, the flag bank and the pin-hold keeper.
// Assumes all event inputs are already synchronous to clk.
module dsw_ctrl #(
    parameter int NUM_IRQ = 4,
    localparam int NSRC  = NUM_IRQ + 2,
    localparam int REG_W = NSRC + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               nmi,
    input  logic               mres,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic               boot_ram,
    input  logic [1:0]         reg_sel,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               standby_o,
    output logic               wake_pulse_o,
    output logic               hold_bus_o,
    output logic               hold_io_o
);
    import dsw_pkg::*;

    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] ev_raw;
    logic [NSRC-1:0] ev_qual;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] clr_mask;
    logic            enter, wake, capture, keep;
    logic            sel_mask, sel_flag;

    // Gather raw events in register bit order
    always_comb begin
        ev_raw           = '0;
        ev_raw[SRC_NMI]  = nmi;
        ev_raw[SRC_MRES] = mres;
        for (int i = 0; i < NUM_IRQ; i++)
            ev_raw[SRC_IRQ0 + i] = irq[i];
        ev_qual = ev_raw & mask_q;
    end

    // Register select decode
    always_comb begin
        sel_mask = dsw_reg_e'(reg_sel) == REG_MASK;
        sel_flag = dsw_reg_e'(reg_sel) == REG_FLAG;
        clr_mask = (reg_wr && sel_flag) ? reg_wdata[NSRC-1:0] : '0;
    end

    // Wake-source select mask
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr && sel_mask)
            mask_q <= reg_wdata[NSRC-1:0];
    end

    dsw_seq #(.NSRC(NSRC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .ev_qual      (ev_qual),
        .standby_o    (standby_o),
        .wake_pulse_o (wake_pulse_o),
        .enter_o      (enter),
        .wake_o       (wake),
        .capture_o    (capture)
    );

    dsw_flags #(.NSRC(NSRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .ev_qual  (ev_qual),
        .clr_mask (clr_mask),
        .flags_o  (flags)
    );

    dsw_retain u_retain (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby_o),
        .enter      (enter),
        .wake       (wake),
        .boot_ram   (boot_ram),
        .rd_keep    (reg_rd && sel_flag),
        .wr_keep    (reg_wr && sel_flag),
        .wdata_keep (reg_wdata[NSRC]),
        .keep_o     (keep),
        .hold_bus_o (hold_bus_o),
        .hold_io_o  (hold_io_o)
    );

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (dsw_reg_e'(reg_sel))
            REG_MASK: reg_rdata[NSRC-1:0] = mask_q;
            REG_FLAG: reg_rdata = {keep, flags};
            REG_STAT: begin
                reg_rdata[0] = standby_o;
                reg_rdata[1] = boot_ram;
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_hold_implies_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_io_o |-> keep);
    assert_standby_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> (hold_io_o && hold_bus_o));
endmodule

// File: tb/test_dsw_ctrl.sv
module test_dsw_ctrl;
    localparam int NUM_IRQ = 4;
    localparam int NSRC    = NUM_IRQ + 2;
    localparam int REG_W   = NSRC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, nmi = 1'b0, mres = 1'b0, boot_ram = 1'b0;
    logic [NUM_IRQ-1:0] irq = '0;
    logic [1:0] reg_sel = 2'd0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic standby_o, wake_pulse_o, hold_bus_o, hold_io_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dsw_ctrl #(.NUM_IRQ(NUM_IRQ)) i_dsw_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .nmi(nmi), .mres(mres),
        .irq(irq), .boot_ram(boot_ram), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .standby_o(standby_o), .wake_pulse_o(wake_pulse_o),
        .hold_bus_o(hold_bus_o), .hold_io_o(hold_io_o)
    );

    // Vector: [21:16] mask, [15] boot_ram, [14:9] events, [8] wake,
    //         [7:2] expected flags, [1] hold_bus, [0] hold_io
    localparam logic [21:0] VEC [6] = '{
        {6'b000001, 1'b0, 6'b000001, 1'b1, 6'b000001, 1'b0, 1'b1},
        {6'b000001, 1'b1, 6'b000001, 1'b1, 6'b000001, 1'b1, 1'b1},
        {6'b111100, 1'b0, 6'b010100, 1'b1, 6'b010100, 1'b0, 1'b1},
        {6'b000100, 1'b0, 6'b001011, 1'b0, 6'b000000, 1'b1, 1'b1},
        {6'b000110, 1'b1, 6'b001110, 1'b1, 6'b000110, 1'b1, 1'b1},
        {6'b000010, 1'b0, 6'b000010, 1'b1, 6'b000010, 1'b0, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [REG_W-1:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [REG_W-1:0] d);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic set_ev(input logic [NSRC-1:0] e);
        nmi = e[0]; mres = e[1]; irq = e[NSRC-1:2];
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [REG_W-1:0] d;
        #2;
        do_reset();
        // R1 reset state
        chk("R1 standby", REG_W'(standby_o), 0);
        chk("R1 wake", REG_W'(wake_pulse_o), 0);
        chk("R1 holds", REG_W'({hold_bus_o, hold_io_o}), 0);
        rd(2'd0, d); chk("R1 mask reg", d, 0);
        rd(2'd1, d); chk("R1 flag reg", d, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R12
        for (int v = 0; v < 6; v++) begin
            do_reset();
            wr(2'd0, REG_W'(VEC[v][21:16]));
            boot_ram = VEC[v][15];
            sleep_req = 1'b1;
            step();
            sleep_req = 1'b0;
            chk("R2 standby entry", REG_W'(standby_o), 1);
            chk("R2 holds at entry", REG_W'({hold_bus_o, hold_io_o}), 3);
            set_ev(VEC[v][14:9]);
            step();
            set_ev('0);
            chk("R3/R4 standby after event", REG_W'(standby_o), REG_W'(!VEC[v][8]));
            chk("R4 wake pulse", REG_W'(wake_pulse_o), REG_W'(VEC[v][8]));
            chk("R6/R7 holds after event", REG_W'({hold_bus_o, hold_io_o}), REG_W'(VEC[v][1:0]));
            rd(2'd1, d);
            chk("R5/R12 flags", REG_W'(d[NSRC-1:0]), REG_W'(VEC[v][7:2]));
            chk("R4 pulse one cycle", REG_W'(wake_pulse_o), 0);
        end

        // R12 status register and unused select
        do_reset();
        boot_ram = 1'b1;
        wr(2'd0, 7'h01);
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        rd(2'd2, d); chk("R12 status standby+boot", d, 7'h03);
        rd(2'd3, d); chk("R12 select 3 reads 0", d, 0);
        rd(2'd0, d); chk("R12 mask readback", d, 7'h01);
        set_ev(6'b000001); step(); set_ev('0);
        rd(2'd2, d); chk("R12 status after wake", d, 7'h02);

        // R9 unarmed write of 0 keeps holds
        wr(2'd1, 7'h00);
        chk("R9 unarmed write", REG_W'({hold_bus_o, hold_io_o}), 3);
        rd(2'd1, d); chk("R9 hold bit still 1", REG_W'(d[NSRC]), 1);
        wr(2'd1, 7'h40);
        chk("R9 write 1 no release", REG_W'({hold_bus_o, hold_io_o}), 3);
        wr(2'd1, 7'h00);
        chk("R9 write 1 cancels arm", REG_W'(hold_io_o), 1);

        // R8 read 1 then write 0 releases
        rd(2'd1, d); chk("R8 hold bit reads 1", REG_W'(d[NSRC]), 1);
        wr(2'd1, 7'h00);
        chk("R8 holds released", REG_W'({hold_bus_o, hold_io_o}), 0);
        rd(2'd1, d); chk("R8 hold bit cleared, flag kept", d, 7'h01);

        // R11 flag write-1-clear and hold bit not software settable
        wr(2'd1, 7'h01);
        rd(2'd1, d); chk("R11 flag cleared", d, 0);
        wr(2'd1, 7'h40);
        rd(2'd1, d); chk("R11 hold bit not settable", d, 0);
        chk("R11 holds stay low", REG_W'({hold_bus_o, hold_io_o}), 0);

        // R10 sleep request coinciding with a selected event
        do_reset();
        wr(2'd0, 7'h01);
        sleep_req = 1'b1; nmi = 1'b1;
        step();
        sleep_req = 1'b0; nmi = 1'b0;
        chk("R10 no entry", REG_W'(standby_o), 0);
        chk("R10 wake pulse", REG_W'(wake_pulse_o), 1);
        chk("R10 holds not raised", REG_W'({hold_bus_o, hold_io_o}), 0);
        rd(2'd1, d); chk("R10 flag set", d, 7'h01);

        finish_run();
    end
endmodule